// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a binary counter built from identical narrow stages. Every stored bit changes on the rising clock edge. Three controls act only at that edge, in a fixed order of precedence. An active-low clear zeroes the count. An active-low load presets the count from a data word. Counting advances the count by one, but only when both count enables are high. One enable, `en_par`, goes to every stage. The other, `en_trk`, enters the lowest stage and then passes upward through each stage's carry.

Each stage drives a carry output. The carry is the stage's tracking enable ANDed with an all-ones detect of that stage's count, and it is purely combinational. The carry of one stage is the tracking enable of the stage above it. Because of this, the chain counts as one wide binary counter without any extra logic. The carry of the top stage leaves the block, so a second block can extend the chain. The block has no reset port. Until the first clear or load, the count is unknown.

Top module: `ctr_chain`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, the whole count becomes 0 on that edge, whatever the load, enable and data inputs are.
- R2: When `clr_n` is 1 and `load_n` is 0 at a rising edge, the count takes the value of `din` on that edge, whatever the enables are. Any value can be preset.
- R3: When `clr_n`, `load_n`, `en_par` and `en_trk` are all 1 at a rising edge, the count advances by one.
- R4: When `clr_n` and `load_n` are 1 and `en_par` is 0, the count holds.
- R5: When `clr_n` and `load_n` are 1 and `en_trk` is 0, the count holds.
- R6: Counting from the all-ones value wraps the count to 0.
- R7: `carry_out` is 1 exactly when `en_trk` is 1 and every count bit is 1. A change on `en_trk` reaches `carry_out` with no clock edge.
- R8: Stages chain through their carries. A stage counts only when every stage below it is at all-ones, so the full count behaves as one binary number. For example, 0x0FF advances to 0x100.
- R9: Bit 0 of `din` and of `q` is the least significant bit of the count.
- R10: Pulses on `clr_n`, `load_n`, `en_par` or `en_trk` that begin and end between two rising edges do not change the stored count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state bit updates on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest precedence |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Count enable shared by all stages |
| en_trk | input | 1 | Count enable into the lowest stage; also gates the carry |
| din | input | STAGE_W*STAGES | Preset value, bit 0 least significant |
| q | output | STAGE_W*STAGES | Current count |
| carry_out | output | 1 | Carry of the top stage |

## Verification
Clear, load and count can all be requested at the same edge, and the precedence among them is the main risk. The bench holds both enables high while it asserts load, and checks that the count equals `din` and not the incremented value. It then asserts clear and load together with a nonzero `din`, and checks that the count is zero. In a second overlap, `en_trk` is lowered and raised between edges while the count is at all-ones. The bench checks that `carry_out` follows `en_trk` at once, and that the following edge still wraps the count.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } ctr_mode_e;
endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
  import ctr_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output ctr_mode_e mode
);
  // Fixed precedence: clear, then load, then count, else hold.
  always_comb begin
    if (!clr_n)                mode = MODE_CLEAR;
    else if (!load_n)          mode = MODE_LOAD;
    else if (en_par && en_trk) mode = MODE_COUNT;
    else                       mode = MODE_HOLD;
  end
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  ctr_mode_e    mode;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd;

  ctr_mode_dec u_dec (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .mode   (mode)
  );

  // Next-state selection.
  always_comb begin
    unique case (mode)
      MODE_CLEAR: q_nxt = '0;
      MODE_LOAD:  q_nxt = din;
      MODE_COUNT: q_nxt = q_r + 1'b1;
      default:    q_nxt = q_r;
    endcase
  end

  // The register is written only when the mode is not hold.
  assign upd = (mode != MODE_HOLD);

  always_ff @(posedge clk) begin
    if (upd) q_r <= q_nxt;
  end

  assign q     = q_r;
  assign carry = en_trk & (q_r == ALL_ONES);

  // Assertions are enabled only after the first clear or load.
  logic armed;
  always_ff @(posedge clk) begin
    if (!clr_n || !load_n) armed <= 1'b1;
  end

  a_r1_clear: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    !clr_n |=> (q == '0));
  a_r2_load: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (clr_n && !load_n) |=> (q == $past(din)));
  a_r4_hold_par: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (clr_n && load_n && !en_par) |=> $stable(q));
  a_r5_hold_trk: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (clr_n && load_n && !en_trk) |=> $stable(q));
  a_r6_wrap: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (carry && clr_n && load_n && en_par) |=> (q == '0));
endmodule

// File: rtl/ctr_chain.sv
module ctr_chain
  import ctr_pkg::*;
#(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 3
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       en_par,
  input  logic                       en_trk,
  input  logic [STAGE_W*STAGES-1:0]  din,
  output logic [STAGE_W*STAGES-1:0]  q,
  output logic                       carry_out
);
  localparam int TOTAL_W = STAGE_W * STAGES;

  logic [STAGES-1:0] trk;
  logic [STAGES-1:0] cy;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign trk[i] = en_trk;
    end else begin : g_next
      assign trk[i] = cy[i-1];
    end

    ctr_stage #(.W(STAGE_W)) u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_par (en_par),
      .en_trk (trk[i]),
      .din    (din[i*STAGE_W +: STAGE_W]),
      .q      (q[i*STAGE_W +: STAGE_W]),
      .carry  (cy[i])
    );
  end

  assign carry_out = cy[STAGES-1];

  logic armed;
  always_ff @(posedge clk) begin
    if (!clr_n || !load_n) armed <= 1'b1;
  end

  a_r7_carry_term: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    carry_out |-> (en_trk && (q == {TOTAL_W{1'b1}})));
  a_r3_count: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (clr_n && load_n && en_par && en_trk) |=>
      (q == TOTAL_W'($past(q) + 1'b1)));
endmodule

// File: tb/tb_ctr_chain.sv
module tb_ctr_chain;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int W  = SW * NS;

  logic         clk = 1'b0;
  logic         clr_n, load_n, en_par, en_trk;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ctr_chain #(.STAGE_W(SW), .STAGES(NS)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .q(q), .carry_out(carry_out)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Inputs change at the falling edge; results are sampled at the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic c, input logic l, input logic p, input logic t);
    clr_n = c; load_n = l; en_par = p; en_trk = t;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    set_ctl(1, 0, 0, 0); din = v; tick();
  endtask

  task automatic t_clear();
    do_load(12'h5A5);
    set_ctl(0, 1, 1, 1); tick();
    chk("R1 clear", q, '0);
    chk("R1 carry after clear", {{(W-1){1'b0}}, carry_out}, '0);
  endtask

  task automatic t_load();
    do_load(12'h001); chk("R9 lsb load", q, 12'h001);
    do_load(12'h800); chk("R2 msb load", q, 12'h800);
    do_load(12'hC3F); chk("R2 arbitrary load", q, 12'hC3F);
  endtask

  task automatic t_count();
    do_load(12'h0FE);
    set_ctl(1, 1, 1, 1); tick();
    chk("R3 count", q, 12'h0FF);
    tick();
    chk("R8 two-stage carry", q, 12'h100);
    do_load(12'h00F);
    set_ctl(1, 1, 1, 1); tick();
    chk("R8 one-stage carry", q, 12'h010);
    tick(); tick();
    chk("R3 count run", q, 12'h012);
  endtask

  task automatic t_hold();
    do_load(12'h0FF);
    set_ctl(1, 1, 0, 1); tick(); tick();
    chk("R4 hold en_par low", q, 12'h0FF);
    set_ctl(1, 1, 1, 0); tick(); tick();
    chk("R5 hold en_trk low", q, 12'h0FF);
  endtask

  task automatic t_wrap();
    do_load(12'hFFF);
    set_ctl(1, 1, 0, 1); #1;
    chk("R7 carry at all-ones", {{(W-1){1'b0}}, carry_out}, 12'h001);
    en_trk = 1'b0; #1;
    chk("R7 carry follows en_trk low", {{(W-1){1'b0}}, carry_out}, '0);
    en_trk = 1'b1; #1;
    chk("R7 carry follows en_trk high", {{(W-1){1'b0}}, carry_out}, 12'h001);
    en_par = 1'b1;
    tick();
    chk("R6 wrap", q, '0);
    chk("R7 carry clear after wrap", {{(W-1){1'b0}}, carry_out}, '0);
  endtask

  task automatic t_prio();
    do_load(12'h010);
    din = 12'hABC;
    set_ctl(0, 0, 1, 1); tick();
    chk("R1 clear beats load", q, '0);
    din = 12'h3C7;
    set_ctl(1, 0, 1, 1); tick();
    chk("R2 load beats count", q, 12'h3C7);
  endtask

  task automatic t_glitch();
    do_load(12'h456);
    set_ctl(1, 1, 0, 0);
    #1 clr_n = 1'b0; load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din = 12'h000;
    #2 clr_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
    tick();
    chk("R10 pulse between edges", q, 12'h456);
  endtask

  initial begin
    set_ctl(0, 1, 0, 0);
    din = '0;
    @(negedge clk);
    tick();
    chk("R1 initial clear", q, '0);
    t_clear();
    t_load();
    t_count();
    t_hold();
    t_wrap();
    t_prio();
    t_glitch();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule